// File: doc/BRIEF.md
# SHA-256 Four-Round Hash Step Unit

This unit advances a SHA-256 working state by four compression rounds per request. The eight-word state arrives split across two 128-bit operands: a destination operand and a source operand. A third operand carries four words that already combine the round constant with the message schedule. One round is computed per clock cycle. Each 128-bit operand holds four 32-bit lanes. Lane i sits in bits 32i+31 down to 32i, so the least significant byte comes first in memory order.

The unit applies these definitions throughout. The "high half" (X) holds the words a, b, c, d in lanes 0 to 3. The "low half" (Y) holds e, f, g, h in lanes 0 to 3. In each round, choose(e,f,g) and majority(a,b,c) feed the standard update, with Sigma1 = ror6^ror11^ror25 and Sigma0 = ror2^ror13^ror22. The new e is d + t, the new a is t + Sigma0(a) + majority, and the remaining words shift by one lane. The `mode` input selects the operand roles. With mode 0 the destination is the high half and the new high half is returned. With mode 1 the destination is the low half, the source is the high half, and the new low half is returned.

The controller has three states. ST_IDLE waits for a request. ST_ROUND runs the four rounds. ST_HOLD presents the result. The transitions are:
- accept (ST_IDLE to ST_ROUND): taken when `in_valid` is high while idle.
- step (ST_ROUND to itself): taken for rounds 0 to 2.
- finish (ST_ROUND to ST_HOLD): taken after round 3.
- drain (ST_HOLD to ST_IDLE): taken when `out_ready` is high.

Top module: `sha256_quad_round`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is high only in ST_IDLE. A request offered while a computation is in progress is ignored: it neither changes the pending result nor starts a new operation.
- R3: `out_valid` rises exactly four clock edges after the edge that accepts a request (`in_valid` and `in_ready` both high).
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `result` holds its value.
- R5: With mode 0, `result` equals lanes a..d (lane 0 = a) of the state after four rounds. The starting state is a..d taken from `dst_in` and e..h taken from `src_in`.
- R6: With mode 1, `result` equals lanes e..h (lane 0 = e) of the state after four rounds. The starting state is a..d taken from `src_in` and e..h taken from `dst_in`.
- R7: Round r (r = 0..3) uses lane r of `sched_in`. Permuting the lanes changes the result accordingly.
- R8: All additions wrap modulo 2^32, including with all-ones operands.
- R9: After a handshake in which `out_valid` and `out_ready` are both high, the unit returns to ST_IDLE: `in_ready` is 1 on the next cycle and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle, request will be taken |
| mode | input | 1 | 0: destination is the high half; 1: destination is the low half |
| dst_in | input | 128 | Destination state operand |
| src_in | input | 128 | Source state operand |
| sched_in | input | 128 | Four constant-plus-schedule words |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 128 | Selected half of the new state |

## Verification
Any corruption of one state word reaches `result` after the four rounds. This happens because every word either rotates into the returned half or feeds the round sums. The error therefore shows at the ports on the very cycle `out_valid` rises.

A miscounted round index appears as `out_valid` rising one cycle early or late. It also appears as a wrong schedule lane being consumed. A stuck FSM shows up as a mismatch on `in_ready` within one cycle of the expected transition.

The reference model recomputes the rounds with named working variables. It tracks the expected handshake state independently and compares it against the outputs on every clock.

// File: rtl/sha256_qr_pkg.sv
package sha256_qr_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = 4;
    localparam int ROUNDS = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [LANES-1:0] quad_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_HOLD  = 2'd2
    } fsm_e;

    function automatic word_t rotr(input word_t v, input int n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(input word_t v);
        return rotr(v, 2) ^ rotr(v, 13) ^ rotr(v, 22);
    endfunction

    function automatic word_t big_sig1(input word_t v);
        return rotr(v, 6) ^ rotr(v, 11) ^ rotr(v, 25);
    endfunction

    function automatic word_t f_choose(input word_t s, input word_t t, input word_t u);
        return (s & t) | (~s & u);
    endfunction

    function automatic word_t f_major(input word_t s, input word_t t, input word_t u);
        return (s & t) | (s & u) | (t & u);
    endfunction

endpackage

// File: rtl/sha256_qr_round.sv
module sha256_qr_round
    import sha256_qr_pkg::*;
(
    input  quad_t hi_i,
    input  quad_t lo_i,
    input  word_t kw_i,
    output quad_t hi_o,
    output quad_t lo_o
);
    localparam int TOP = LANES - 1;

    word_t ch_v, mj_v, t_sum, new_e, new_a;

    always_comb begin
        ch_v  = f_choose(lo_i[0], lo_i[1], lo_i[2]);
        mj_v  = f_major(hi_i[0], hi_i[1], hi_i[2]);
        t_sum = lo_i[TOP] + big_sig1(lo_i[0]) + ch_v + kw_i;
        new_e = hi_i[TOP] + t_sum;
        new_a = t_sum + big_sig0(hi_i[0]) + mj_v;
    end

    assign hi_o[0] = new_a;
    assign lo_o[0] = new_e;

    for (genvar i = 1; i < LANES; i++) begin : g_shift
        assign hi_o[i] = hi_i[i-1];
        assign lo_o[i] = lo_i[i-1];
    end

endmodule

// File: rtl/sha256_qr_ctrl.sv
module sha256_qr_ctrl
    import sha256_qr_pkg::*;
#(
    parameter int N_ROUNDS = ROUNDS,
    localparam int CNT_W   = (N_ROUNDS > 1) ? $clog2(N_ROUNDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             load_en,
    output logic             step_en,
    output logic [CNT_W-1:0] round_idx
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_ROUNDS - 1);

    fsm_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid)          state_d = ST_ROUND;
            ST_ROUND: if (round_idx == LAST) state_d = ST_HOLD;
            ST_HOLD:  if (out_ready)         state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_HOLD);
        load_en   = in_ready && in_valid;
        step_en   = (state_q == ST_ROUND);
    end

    always_ff @(posedge clk) begin
        if (rst || load_en)              round_idx <= '0;
        else if (step_en && round_idx != LAST) round_idx <= round_idx + 1'b1;
        else if (step_en)                round_idx <= '0;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> !in_ready);

    assert_valid_after_last_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> ($past(step_en) && $past(round_idx) == LAST));

    assert_idle_after_drain_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

endmodule

// File: rtl/sha256_quad_round.sv
module sha256_quad_round
    import sha256_qr_pkg::*;
#(
    localparam int DW = WORD_W * LANES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          mode,
    input  logic [DW-1:0] dst_in,
    input  logic [DW-1:0] src_in,
    input  logic [DW-1:0] sched_in,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] result
);
    localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

    logic             load_en, step_en;
    logic [CNT_W-1:0] round_idx;
    quad_t            hi_q, lo_q, kw_q, hi_n, lo_n;
    logic             mode_q;

    sha256_qr_ctrl #(.N_ROUNDS(ROUNDS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load_en   (load_en),
        .step_en   (step_en),
        .round_idx (round_idx)
    );

    sha256_qr_round u_round (
        .hi_i (hi_q),
        .lo_i (lo_q),
        .kw_i (kw_q[round_idx]),
        .hi_o (hi_n),
        .lo_o (lo_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            kw_q   <= '0;
            mode_q <= 1'b0;
        end else if (load_en) begin
            hi_q   <= mode ? quad_t'(src_in) : quad_t'(dst_in);
            lo_q   <= mode ? quad_t'(dst_in) : quad_t'(src_in);
            kw_q   <= quad_t'(sched_in);
            mode_q <= mode;
        end else if (step_en) begin
            hi_q <= hi_n;
            lo_q <= lo_n;
        end
    end

    assign result = mode_q ? DW'(lo_q) : DW'(hi_q);

    assert_hold_result_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(result)));

    assert_state_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !load_en) |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: tb/tb_sha256_quad_round.sv
`timescale 1ns/1ps
module tb_sha256_quad_round;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         mode = 1'b0;
    logic [127:0] dst_in = '0, src_in = '0, sched_in = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] result;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string cur_tag = "R5";

    always #2.5 clk = ~clk;

    sha256_quad_round dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .mode(mode), .dst_in(dst_in), .src_in(src_in), .sched_in(sched_in),
        .out_valid(out_valid), .out_ready(out_ready), .result(result)
    );

    function automatic logic [31:0] rr(input logic [31:0] v, input int n);
        return (v >> n) | (v << (32 - n));
    endfunction

    // Returns {h,g,f,e,d,c,b,a}: low 128 bits = a..d, high = e..h
    function automatic logic [255:0] run4(input logic [127:0] abcd,
                                          input logic [127:0] efgh,
                                          input logic [127:0] k);
        logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
        {d, c, b, a} = abcd;
        {h, g, f, e} = efgh;
        for (int r = 0; r < 4; r++) begin
            t1 = h + (rr(e,6) ^ rr(e,11) ^ rr(e,25)) + ((e & f) ^ (~e & g)) + k[32*r +: 32];
            t2 = (rr(a,2) ^ rr(a,13) ^ rr(a,22)) + ((a & b) ^ (a & c) ^ (b & c));
            h = g; g = f; f = e; e = d + t1;
            d = c; c = b; b = a; a = t1 + t2;
        end
        return {h, g, f, e, d, c, b, a};
    endfunction

    // Behavioural model: 0 idle, 1..4 rounds pending, 5 result presented
    int           m_phase = 0;
    logic [127:0] m_exp = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase <= 0;
        end else begin
            case (m_phase)
                0: if (in_valid) begin
                       m_phase <= 1;
                       m_exp   <= mode ? run4(src_in, dst_in, sched_in)[255:128]
                                       : run4(dst_in, src_in, sched_in)[127:0];
                   end
                5: if (out_ready) m_phase <= 0;
                default: m_phase <= m_phase + 1;
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!rst && !finished) begin
            check(in_ready === (m_phase == 0), "R2", "in_ready",
                  128'(in_ready), 128'(m_phase == 0));
            check(out_valid === (m_phase == 5), "R3", "out_valid",
                  128'(out_valid), 128'(m_phase == 5));
            if (m_phase == 5)
                check(result === m_exp, cur_tag, "result", result, m_exp);
        end
    end

    task automatic send(input bit md, input logic [127:0] d, input logic [127:0] s,
                        input logic [127:0] k, input int hold, input bit poke);
        logic [127:0] first;
        @(negedge clk);
        mode = md; dst_in = d; src_in = s; sched_in = k; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (poke) begin
            // R2: request offered while rounds run must be ignored
            mode = ~md; dst_in = ~d; src_in = s ^ k; sched_in = ~k; in_valid = 1'b1;
            @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end
        while (!out_valid) @(negedge clk);
        first = result;
        repeat (hold) @(negedge clk);
        check(out_valid === 1'b1 && result === first, "R4", "held result", result, first);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(in_ready === 1'b1 && out_valid === 1'b0, "R9", "idle after drain",
              128'({in_ready, out_valid}), 128'(2'b10));
    endtask

    localparam logic [127:0] ST_A = 128'ha54ff53a_3c6ef372_bb67ae85_6a09e667;
    localparam logic [127:0] ST_E = 128'h5be0cd19_1f83d9ab_9b05688c_510e527f;
    localparam logic [127:0] KW_A = 128'he9b5dba5_b5c0fbcf_71374491_428a2f98;

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs during reset
        check(in_ready === 1'b1 && out_valid === 1'b0, "R1", "reset outputs",
              128'({in_ready, out_valid}), 128'(2'b10));
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        check(in_ready === 1'b1 && out_valid === 1'b0, "R1", "after reset",
              128'({in_ready, out_valid}), 128'(2'b10));

        cur_tag = "R5"; send(1'b0, ST_A, ST_E, KW_A, 3, 1'b0);
        cur_tag = "R6"; send(1'b1, ST_E, ST_A, KW_A, 0, 1'b0);
        cur_tag = "R7"; send(1'b0, ST_A, ST_E, {KW_A[31:0], KW_A[63:32], KW_A[95:64], KW_A[127:96]}, 1, 1'b0);
        cur_tag = "R7"; send(1'b1, ST_E, ST_A, {KW_A[95:0], KW_A[127:96]}, 1, 1'b0);
        cur_tag = "R8"; send(1'b0, '1, '1, '1, 2, 1'b0);
        cur_tag = "R8"; send(1'b1, '1, '1, '1, 0, 1'b0);
        cur_tag = "R2"; send(1'b0, ST_E, ST_A, ~KW_A, 2, 1'b1);
        cur_tag = "R2"; send(1'b1, ST_A, ~ST_E, KW_A, 1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            cur_tag = (i % 2) ? "R6" : "R5";
            send(1'(i % 2), {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, i % 3, 1'(i % 3 == 1));
        end
        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL R3 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule